// File: doc/BRIEF.md
# Critical-Conduction Phase Gate Controller

This block sequences the four gates of one bridgeless totem-pole boost leg that runs in critical conduction mode with a constant on-time. Each switching cycle is started by a rising edge on the zero-current-detect input. The block then waits out a dead interval and turns the control switch on for a programmed number of clocks. After that it waits out a second dead interval and turns the complementary high-frequency switch on as a synchronous rectifier. The rectifier stays on until the next zero-current edge arrives. If no such edge arrives within a maximum off-time, a restart timer ends the rectifier interval by force.

A line-polarity input decides which high-frequency switch is the control switch and which is the rectifier. It also sets the two line-frequency rectifier gates. The polarity is only taken in while both high-frequency gates are off, so a role swap can never cut a conducting gate short. Every edge falls on a controller clock, so the on-time, the dead time and the restart window are whole clock counts. The on-time word and the dead-time word are sampled when the interval that uses them begins.

Top module: `crm_phase_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first turn-on, both high-frequency gates are low, `lf_a_o` is 1 and `lf_b_o` is 0.
- R2: `hf_lo_o` and `hf_hi_o` are never high in the same cycle.
- R3: The control gate stays high for exactly max(N,1) clocks, where N is `ton_i` sampled at the clock edge that turns the gate on; a later change of `ton_i` does not alter that pulse.
- R4: After the control gate falls, both high-frequency gates stay low for exactly max(M,1) clocks, where M is `dead_i` sampled at that edge; the rectifier gate then rises.
- R5: The rectifier gate falls on the clock edge that samples a zero-current rising edge (`zcd_i` high after a low sample). Both high-frequency gates then stay low for max(M,1) clocks, M sampled at that edge, and the control gate rises.
- R6: A zero-current rising edge sampled while the control gate is on, or during a dead interval, has no effect on the gate sequence.
- R7: With `line_pos_i`=1 taken in, the control switch is `hf_lo_o`, the rectifier is `hf_hi_o`, `lf_a_o`=1 and `lf_b_o`=0. With 0 taken in, the two high-frequency roles are swapped and `lf_a_o`=0, `lf_b_o`=1.
- R8: `line_pos_i` is taken in only on a clock edge where both high-frequency gates are low. While either gate is high, the line-frequency gates and the role assignment hold.
- R9: If no zero-current edge is sampled, the rectifier gate falls exactly MAX_OFF clocks after the control gate fell. After max(M,1) clocks with both gates low, the control gate rises.
- R10: After reset the first turn-on follows a zero-current rising edge by max(M,1) clocks of both gates low. If no edge arrives within MAX_OFF clocks of reset, the same start is forced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all gate edges align to it |
| rst_n | input | 1 | Active-low synchronous reset |
| zcd_i | input | 1 | Zero-current-detect level; a rising edge starts a cycle |
| line_pos_i | input | 1 | Line polarity, 1 for the positive half line cycle |
| ton_i | input | CNT_W | On-time in clocks (0 behaves as 1) |
| dead_i | input | DT_W | Dead time in clocks (0 behaves as 1) |
| hf_lo_o | output | 1 | Gate of the bottom high-frequency switch |
| hf_hi_o | output | 1 | Gate of the top high-frequency switch |
| lf_a_o | output | 1 | Gate of the first line-frequency switch |
| lf_b_o | output | 1 | Gate of the second line-frequency switch |

## Verification
The bench builds the block with CNT_W=8, DT_W=4 and MAX_OFF=40. The 8-bit on-time lets both the zero word and the full 255-clock pulse run in a few hundred cycles. The 4-bit dead time covers the zero word and the 15-clock maximum. A 40-clock restart window is short enough that forced restarts, and restarts right after a polarity swap, recur many times in one run. With these values every dead interval also ends well inside the restart window, so the zero-current path and the timeout path can be checked on their own.

// File: rtl/crm_pkg.sv
package crm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DON  = 3'd1,
    ST_ON   = 3'd2,
    ST_DOFF = 3'd3,
    ST_SR   = 3'd4
  } crm_st_e;

  // Length in clocks of an interval programmed with word v (0 acts as 1).
  function automatic int unsigned run_len(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Value loaded into a down-counter so the interval lasts run_len(v) clocks.
  function automatic int unsigned load_val(input int unsigned v);
    return run_len(v) - 1;
  endfunction

  // True in states where both high-frequency gates are off.
  function automatic logic both_off(input crm_st_e s);
    return (s == ST_IDLE) || (s == ST_DON) || (s == ST_DOFF);
  endfunction

endpackage

// File: rtl/crm_zcd_edge.sv
module crm_zcd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic zcd_i,
  output logic evt_o
);
  logic zcd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) zcd_q <= 1'b1;
    else        zcd_q <= zcd_i;
  end

  assign evt_o = zcd_i & ~zcd_q;
endmodule

// File: rtl/crm_off_timer.sv
module crm_off_timer #(
  parameter int MAX_OFF = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic expired_o
);
  localparam int OFF_W = (MAX_OFF > 2) ? $clog2(MAX_OFF) : 1;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(MAX_OFF - 1);

  logic [OFF_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + OFF_W'(1);
  end

  assign expired_o = (cnt_q == LAST);
endmodule

// File: rtl/crm_seq.sv
module crm_seq
  import crm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             expired_i,
  input  logic [CNT_W-1:0] ton_i,
  input  logic [DT_W-1:0]  dead_i,
  output crm_st_e          st_o,
  output logic             off_start_o,
  output logic             restart_o
);
  localparam int PH_W = (CNT_W > DT_W) ? CNT_W : DT_W;

  crm_st_e         st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            waiting, wake, ph_done;
  logic [PH_W-1:0] ton_load, dead_load;

  assign waiting   = (st_q == ST_IDLE) || (st_q == ST_SR);
  assign wake      = waiting && (evt_i || expired_i);
  assign restart_o = waiting && expired_i && !evt_i;
  assign ph_done   = (ph_q == '0);
  assign ton_load  = PH_W'(load_val(int'(ton_i)));
  assign dead_load = PH_W'(load_val(int'(dead_i)));

  always_comb begin
    st_d        = st_q;
    ph_d        = ph_done ? '0 : ph_q - PH_W'(1);
    off_start_o = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_SR: begin
        if (wake) begin
          st_d = ST_DON;
          ph_d = dead_load;
        end
      end
      ST_DON: begin
        if (ph_done) begin
          st_d = ST_ON;
          ph_d = ton_load;
        end
      end
      ST_ON: begin
        if (ph_done) begin
          st_d        = ST_DOFF;
          ph_d        = dead_load;
          off_start_o = 1'b1;
        end
      end
      ST_DOFF: begin
        if (ph_done) st_d = ST_SR;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/crm_gate_map.sv
module crm_gate_map
  import crm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    line_pos_i,
  input  crm_st_e st_i,
  output logic    hf_lo_o,
  output logic    hf_hi_o,
  output logic    lf_a_o,
  output logic    lf_b_o
);
  logic pol_q;
  logic ctrl_on, sr_on;

  always_ff @(posedge clk) begin
    if (!rst_n)              pol_q <= 1'b1;
    else if (both_off(st_i)) pol_q <= line_pos_i;
  end

  assign ctrl_on = (st_i == ST_ON);
  assign sr_on   = (st_i == ST_SR);
  assign hf_lo_o = pol_q ? ctrl_on : sr_on;
  assign hf_hi_o = pol_q ? sr_on   : ctrl_on;
  assign lf_a_o  = pol_q;
  assign lf_b_o  = ~pol_q;
endmodule

// File: rtl/crm_phase_ctrl.sv
module crm_phase_ctrl
  import crm_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int DT_W    = 4,
  parameter int MAX_OFF = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zcd_i,
  input  logic             line_pos_i,
  input  logic [CNT_W-1:0] ton_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             hf_lo_o,
  output logic             hf_hi_o,
  output logic             lf_a_o,
  output logic             lf_b_o
);
  crm_st_e st;
  logic    zcd_evt;
  logic    off_start;
  logic    off_expired;
  logic    restart_fire;

  crm_zcd_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .zcd_i (zcd_i),
    .evt_o (zcd_evt)
  );

  crm_off_timer #(.MAX_OFF(MAX_OFF)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (off_start),
    .expired_o (off_expired)
  );

  crm_seq #(.CNT_W(CNT_W), .DT_W(DT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (zcd_evt),
    .expired_i   (off_expired),
    .ton_i       (ton_i),
    .dead_i      (dead_i),
    .st_o        (st),
    .off_start_o (off_start),
    .restart_o   (restart_fire)
  );

  crm_gate_map u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_pos_i (line_pos_i),
    .st_i       (st),
    .hf_lo_o    (hf_lo_o),
    .hf_hi_o    (hf_hi_o),
    .lf_a_o     (lf_a_o),
    .lf_b_o     (lf_b_o)
  );
endmodule

// File: rtl/crm_phase_ctrl_chk.sv
module crm_phase_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hf_lo_o,
  input logic hf_hi_o,
  input logic lf_a_o,
  input logic lf_b_o,
  input logic zcd_evt,
  input logic restart_fire
);
  logic hf_any, ctrl_on, sr_on;

  assign hf_any  = hf_lo_o | hf_hi_o;
  assign ctrl_on = lf_a_o ? hf_lo_o : hf_hi_o;
  assign sr_on   = lf_a_o ? hf_hi_o : hf_lo_o;

  AST_HF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hf_lo_o && hf_hi_o)); // R2

  AST_LF_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    lf_a_o != lf_b_o); // R7

  AST_LF_HOLD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (hf_any && $past(hf_any)) |-> $stable({lf_a_o, lf_b_o})); // R8

  AST_GAP_BEFORE_SR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_on) |-> $past(!hf_any)); // R4

  AST_SR_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_on) |-> $past(zcd_evt || restart_fire)); // R5

  AST_GAP_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_on) |-> $past(!hf_any)); // R5
endmodule

bind crm_phase_ctrl crm_phase_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hf_lo_o      (hf_lo_o),
  .hf_hi_o      (hf_hi_o),
  .lf_a_o       (lf_a_o),
  .lf_b_o       (lf_b_o),
  .zcd_evt      (zcd_evt),
  .restart_fire (restart_fire)
);

// File: tb/tb_crm_phase_ctrl.sv
`timescale 1ns/1ps
module tb_crm_phase_ctrl;
  localparam int CNT_W   = 8;
  localparam int DT_W    = 4;
  localparam int MAX_OFF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zcd = 1'b0;
  logic line_pos = 1'b1;
  logic [CNT_W-1:0] ton_w = '0;
  logic [DT_W-1:0]  dead_w = '0;
  logic hf_lo, hf_hi, lf_a, lf_b;

  int checks = 0;
  int fails = 0;
  int overlaps = 0;
  bit done = 1'b0;
  logic cur_pol = 1'b1;

  always #5 clk = ~clk;

  crm_phase_ctrl #(.CNT_W(CNT_W), .DT_W(DT_W), .MAX_OFF(MAX_OFF)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .zcd_i      (zcd),
    .line_pos_i (line_pos),
    .ton_i      (ton_w),
    .dead_i     (dead_w),
    .hf_lo_o    (hf_lo),
    .hf_hi_o    (hf_hi),
    .lf_a_o     (lf_a),
    .lf_b_o     (lf_b)
  );

  // R2: watch for overlap on every sample
  always @(negedge clk) if (rst_n && hf_lo && hf_hi) overlaps++;

  // interval length for a programmed word: the zero word still gives one clock
  function automatic int span(input int w);
    return w + int'(w == 0);
  endfunction

  // expected {hf_hi, hf_lo, lf_a, lf_b}
  function automatic logic [3:0] expv(input logic p, input logic c, input logic s);
    if (p) return {s, c, 2'b10};
    return {c, s, 2'b01};
  endfunction

  task automatic chk(input string tag, input int k, input logic [3:0] exp);
    logic [3:0] got;
    got = {hf_hi, hf_lo, lf_a, lf_b};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at sample %0d: actual %b expected %b", tag, k, got, exp);
    end
  endtask

  // Wait, bounded, until the rectifier gate of the current polarity is on.
  task automatic settle();
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (cur_pol ? hf_hi : hf_lo) break;
    end
  endtask

  // Starts in rectifier interval (or idle) right after a negedge sample.
  task automatic run_cycle(input logic pol, input int ton, input int dead,
                           input bit restart, input string extra);
    int d, t, kend;
    logic p_old, c, s, pk;
    string tag;
    d = span(dead);
    t = span(ton);
    p_old = cur_pol;
    kend = restart ? (2*d + t + MAX_OFF + 1) : (2*d + t + 2);
    line_pos = pol;
    ton_w  = CNT_W'(ton);
    dead_w = DT_W'(dead);
    zcd = 1'b1;
    for (int k = 1; k <= kend; k++) begin
      @(negedge clk);
      c = 1'b0; s = 1'b0;
      if (k <= d)                          tag = "R5";
      else if (k <= d + t) begin c = 1'b1; tag = "R3 R6"; end
      else if (k <= 2*d + t)               tag = "R4";
      else if (!restart) begin s = 1'b1;   tag = "R4"; end
      else if (k <= d + t + MAX_OFF) begin s = 1'b1; tag = "R9"; end
      else if (k <= d + t + MAX_OFF + d)   tag = "R9";
      else begin c = 1'b1;                 tag = "R9"; end
      pk = (k == 1) ? p_old : pol;
      if (k == 1 && p_old != pol) tag = {tag, " R8"};
      chk({tag, " R7 ", extra}, k, expv(pk, c, s));
      if (k == 1)     zcd = 1'b0;
      if (k == d + 1) begin ton_w = ton_w ^ 8'h5A; zcd = 1'b1; end  // R3, R6
      if (k == d + 2) zcd = 1'b0;
    end
    cur_pol = pol;
    if (restart) settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int rt, rd;
    logic rp;
    void'($urandom(32'd7321));
    // R1: reset state, regardless of line polarity input
    line_pos = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 0, 4'b0010);
    @(negedge clk);
    chk("R1", 0, 4'b0010);
    line_pos = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 R10", 0, 4'b0010);
    // R10: first start from idle on a zero-current edge
    run_cycle(1'b1, 10, 3, 1'b0, "R10");
    // directed corners
    run_cycle(1'b1, 0, 0, 1'b0, "R3");          // zero words act as one clock
    run_cycle(1'b1, 255, 15, 1'b0, "R3 R4");    // longest on-time and dead time
    run_cycle(1'b0, 7, 2, 1'b0, "R8");          // polarity swap to negative
    run_cycle(1'b0, 5, 4, 1'b1, "R9");          // forced restart, negative
    run_cycle(1'b1, 6, 1, 1'b1, "R8 R9");       // swap then forced restart
    // constrained random
    for (int i = 0; i < 24; i++) begin
      rt = int'($urandom % 48);
      rd = int'($urandom % 16);
      rp = 1'($urandom % 2);
      run_cycle(rp, rt, rd, (i % 5) == 4, "R7");
    end
    @(negedge clk);
    checks++;
    if (overlaps != 0) begin
      fails++;
      $display("FAIL R2: actual %0d overlap samples expected 0", overlaps);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule